// File: doc/BRIEF.md
# Completion Queue Posting Engine

This block sits on the device side of a queue-based storage controller. Command execution hands it one finished-command record at a time. Each record names the submission queue the command came from, the command identifier the host chose, a status code and the device's current head pointer for that submission queue. A static binding table tells the engine which completion queue serves each submission queue, and several submission queues may share one completion queue. The engine builds a 16-byte completion entry, emits it as a host-memory write at the completion queue's tail slot, and advances the tail.

The host consumes entries and reports its progress by writing the completion queue head doorbell. A slot is free only when the host has released it. When the target queue holds depth minus one entries, the record is held with backpressure and is never dropped. Each queue keeps a phase bit in its entries, so the host can find new entries by polling memory alone. For every queue, completions are counted toward an interrupt on that queue's own vector. The interrupt fires when a count threshold or a cycle timeout is reached, whichever comes first.

Top module: `cq_post_engine`

## Requirements
- R1: After reset `wr_valid` and `irq_valid` are low, and `in_ready` is high for every submission queue because all heads and tails are zero.
- R2: An accepted record produces a write one cycle later on `wr_entry`, with bits [127:113] = status, [112] = phase, [111:96] = command id, [95:80] = submission queue id, [79:64] = submission queue head, and [63:0] = zero. `wr_cqid` is the completion queue that `cfg_sq_map` binds to the record's submission queue.
- R3: Each completion queue writes to consecutive slots starting at 0, one slot per accepted record, and wraps from 2**PTR_W-1 back to 0.
- R4: When the target queue's tail plus one equals its head (modulo the depth), `in_ready` is low and no write is issued. The held record is posted unchanged once a doorbell frees a slot.
- R5: The phase bit written is 1 during the first pass through a queue and inverts each time the tail wraps to slot 0.
- R6: With pending count N reaching `cfg_thresh` (a threshold of 0 acts as 1), `irq_valid` pulses for one cycle, beginning one cycle after the Nth record is accepted, and the pending count restarts from zero.
- R7: If the threshold is not reached, the interrupt pulses `cfg_timeout`+1 cycles after the edge that accepted the first pending record.
- R8: Each completion queue has its own pending count and timer. `irq_vec` carries that queue's vector from `cfg_cq_vec`, and posts to one queue never trigger another queue's interrupt.
- R9: Records from different submission queues bound to one completion queue share its slot sequence in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sq_map | input | NUM_SQ*CQ_W | Completion queue bound to each submission queue |
| cfg_cq_vec | input | NUM_CQ*VEC_W | Interrupt vector of each completion queue |
| cfg_thresh | input | CNT_W | Coalescing count threshold |
| cfg_timeout | input | TMR_W | Coalescing timeout in cycles |
| in_valid | input | 1 | Completion record valid |
| in_ready | output | 1 | Target queue has a free slot |
| in_sqid | input | SQ_W | Submission queue of the command |
| in_cid | input | 16 | Command identifier |
| in_status | input | 15 | Completion status |
| in_sqhd | input | 16 | Current submission queue head |
| db_valid | input | 1 | Head doorbell write |
| db_cqid | input | CQ_W | Queue the doorbell targets |
| db_head | input | PTR_W | New head value |
| wr_valid | output | 1 | Entry write to host memory |
| wr_cqid | output | CQ_W | Queue being written |
| wr_index | output | PTR_W | Slot being written |
| wr_entry | output | 128 | Completion entry |
| irq_valid | output | 1 | Interrupt pulse |
| irq_vec | output | VEC_W | Vector of the interrupt |

## Verification
The posting path is exercised with records from two submission queues that share one completion queue, and with a record from a submission queue bound to the other queue. These cases separate a mapping fault from a slot-ordering fault. A fill-to-full run with a delayed doorbell shows whether backpressure holds the record, whether the slot and phase after the wrap are right, and whether anything is dropped. Three coalescing patterns are applied: back-to-back posts against a small threshold, a lone post left to time out, and posts split across both queues under a shared threshold. Together they tell apart count-triggered firing, timer-triggered firing and cross-queue leakage, and each is checked against an exact firing cycle and vector.

// File: rtl/cq_post_engine.sv
module cq_post_engine #(
  parameter int NUM_SQ = 4,
  parameter int NUM_CQ = 2,
  parameter int PTR_W  = 3,
  parameter int VEC_W  = 5,
  parameter int CNT_W  = 8,
  parameter int TMR_W  = 16,
  localparam int SQ_W  = (NUM_SQ > 1) ? $clog2(NUM_SQ) : 1,
  localparam int CQ_W  = (NUM_CQ > 1) ? $clog2(NUM_CQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SQ*CQ_W-1:0]  cfg_sq_map,
  input  logic [NUM_CQ*VEC_W-1:0] cfg_cq_vec,
  input  logic [CNT_W-1:0]        cfg_thresh,
  input  logic [TMR_W-1:0]        cfg_timeout,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SQ_W-1:0]         in_sqid,
  input  logic [15:0]             in_cid,
  input  logic [14:0]             in_status,
  input  logic [15:0]             in_sqhd,
  input  logic                    db_valid,
  input  logic [CQ_W-1:0]         db_cqid,
  input  logic [PTR_W-1:0]        db_head,
  output logic                    wr_valid,
  output logic [CQ_W-1:0]         wr_cqid,
  output logic [PTR_W-1:0]        wr_index,
  output logic [127:0]            wr_entry,
  output logic                    irq_valid,
  output logic [VEC_W-1:0]        irq_vec
);

  logic [PTR_W-1:0] tail_q  [NUM_CQ];
  logic [PTR_W-1:0] head_q  [NUM_CQ];
  logic             phase_q [NUM_CQ];
  logic [CNT_W-1:0] pcnt_q  [NUM_CQ];
  logic [TMR_W-1:0] tmr_q   [NUM_CQ];

  logic [CQ_W-1:0] tgt;
  logic            accept;
  logic [NUM_CQ-1:0] fire;
  logic            fire_any;
  logic [CQ_W-1:0] sel;
  logic            pend_any;

  assign tgt      = cfg_sq_map[in_sqid*CQ_W +: CQ_W];
  assign in_ready = PTR_W'(tail_q[tgt] + 1'b1) != head_q[tgt];
  assign accept   = in_valid && in_ready;
  assign fire_any = |fire;

  always_comb begin
    sel      = '0;
    pend_any = 1'b0;
    for (int c = NUM_CQ - 1; c >= 0; c--) begin
      fire[c] = (pcnt_q[c] != '0) &&
                ((pcnt_q[c] >= cfg_thresh) || (tmr_q[c] >= cfg_timeout));
      if (fire[c]) sel = CQ_W'(c);
      if (pcnt_q[c] != '0) pend_any = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      wr_cqid   <= '0;
      wr_index  <= '0;
      wr_entry  <= '0;
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      for (int c = 0; c < NUM_CQ; c++) begin
        tail_q[c]  <= '0;
        head_q[c]  <= '0;
        phase_q[c] <= 1'b1;
        pcnt_q[c]  <= '0;
        tmr_q[c]   <= '0;
      end
    end else begin
      wr_valid  <= accept;
      irq_valid <= fire_any;
      if (fire_any) irq_vec <= cfg_cq_vec[sel*VEC_W +: VEC_W];
      if (accept) begin
        wr_cqid  <= tgt;
        wr_index <= tail_q[tgt];
        wr_entry <= {in_status, phase_q[tgt], in_cid, 16'(in_sqid), in_sqhd, 64'd0};
        tail_q[tgt] <= PTR_W'(tail_q[tgt] + 1'b1);
        if (tail_q[tgt] == '1) phase_q[tgt] <= ~phase_q[tgt];
      end
      if (db_valid) head_q[db_cqid] <= db_head;
      for (int c = 0; c < NUM_CQ; c++) begin
        if (fire_any && sel == CQ_W'(c)) begin
          pcnt_q[c] <= (accept && tgt == CQ_W'(c)) ? CNT_W'(1) : '0;
          tmr_q[c]  <= '0;
        end else if (accept && tgt == CQ_W'(c)) begin
          if (pcnt_q[c] != '1) pcnt_q[c] <= pcnt_q[c] + 1'b1;
          if (pcnt_q[c] == '0) tmr_q[c] <= '0;
          else if (tmr_q[c] != '1) tmr_q[c] <= tmr_q[c] + 1'b1;
        end else if (pcnt_q[c] != '0 && tmr_q[c] != '1) begin
          tmr_q[c] <= tmr_q[c] + 1'b1;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !db_valid |=> tail_q[$past(tgt)] != head_q[$past(tgt)]); // R4
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> !wr_valid); // R4
  AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> tail_q[wr_cqid] == PTR_W'(wr_index + 1'b1)); // R3
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_index == '1 |-> phase_q[wr_cqid] != wr_entry[112]); // R5
  AST_IRQ_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(pend_any)); // R6

endmodule

// File: tb/cq_post_engine_tb.sv
module cq_post_engine_tb_top;
  localparam int PTR_W = 3, VEC_W = 5, CNT_W = 8, TMR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  cfg_sq_map = 4'b1100;           // SQ0,SQ1->CQ0; SQ2,SQ3->CQ1
  logic [9:0]  cfg_cq_vec = {5'd9, 5'd5};       // CQ0->5, CQ1->9
  logic [CNT_W-1:0] cfg_thresh = 8'd100;
  logic [TMR_W-1:0] cfg_timeout = 16'd1000;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_sqid = '0;
  logic [15:0] in_cid = '0, in_sqhd = '0;
  logic [14:0] in_status = '0;
  logic db_valid = 1'b0, db_cqid = 1'b0;
  logic [PTR_W-1:0] db_head = '0;
  logic wr_valid, wr_cqid, irq_valid;
  logic [PTR_W-1:0] wr_index;
  logic [127:0] wr_entry;
  logic [VEC_W-1:0] irq_vec;

  int checks = 0, fails = 0, cyc = 0;
  int irq_cnt = 0, irq_cyc = 0, acc_cyc = 0;
  logic [VEC_W-1:0] irq_last = '0;

  cq_post_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sq_map(cfg_sq_map), .cfg_cq_vec(cfg_cq_vec),
    .cfg_thresh(cfg_thresh), .cfg_timeout(cfg_timeout),
    .in_valid(in_valid), .in_ready(in_ready), .in_sqid(in_sqid), .in_cid(in_cid),
    .in_status(in_status), .in_sqhd(in_sqhd),
    .db_valid(db_valid), .db_cqid(db_cqid), .db_head(db_head),
    .wr_valid(wr_valid), .wr_cqid(wr_cqid), .wr_index(wr_index), .wr_entry(wr_entry),
    .irq_valid(irq_valid), .irq_vec(irq_vec));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (irq_valid) begin
    irq_cnt++; irq_cyc = cyc; irq_last = irq_vec;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0; db_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; irq_cnt = 0;
  endtask

  task automatic post(input logic [1:0] sq, input logic [15:0] cid,
                      input logic exp_cq, input logic [PTR_W-1:0] exp_idx, input logic exp_ph);
    @(negedge clk);
    in_valid = 1'b1; in_sqid = sq; in_cid = cid;
    in_status = 15'(cid ^ 16'h0a5); in_sqhd = cid + 16'd3;
    chk("R4 ready", in_ready, 1'b1);
    @(posedge clk); #1;
    acc_cyc = cyc;
    chk("R2 wr_valid", wr_valid, 1'b1);
    chk("R2 cqid", wr_cqid, exp_cq);
    chk("R3 index", wr_index, exp_idx);
    chk("R2 entry", wr_entry, {15'(cid ^ 16'h0a5), exp_ph, cid, 14'd0, sq, cid + 16'd3, 64'd0});
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 wr_valid", wr_valid, 1'b0);
    chk("R1 irq_valid", irq_valid, 1'b0);
    for (int s = 0; s < 4; s++) begin
      in_sqid = 2'(s); #1;
      chk("R1 ready", in_ready, 1'b1);
    end
  endtask

  task automatic t_shared();
    cfg_thresh = 8'd100; cfg_timeout = 16'd1000;
    do_reset();
    post(2'd1, 16'h1234, 1'b0, 3'd0, 1'b1);   // R2
    post(2'd0, 16'h0042, 1'b0, 3'd1, 1'b1);   // R9 shared sequence
    post(2'd2, 16'h0777, 1'b1, 3'd0, 1'b1);   // R2 other queue
    post(2'd1, 16'h0099, 1'b0, 3'd2, 1'b1);   // R9
    idle();
  endtask

  task automatic t_full_wrap();
    cfg_thresh = 8'd100; cfg_timeout = 16'd1000;
    do_reset();
    for (int i = 0; i < 7; i++) post(2'(i % 2), 16'(i), 1'b0, 3'(i), 1'b1);
    @(negedge clk); in_sqid = 2'd0; in_cid = 16'h00ee;
    for (int i = 0; i < 4; i++) begin
      chk("R4 stall ready", in_ready, 1'b0);
      @(posedge clk); #1;
      chk("R4 no write", wr_valid, 1'b0);
      @(negedge clk);
    end
    db_valid = 1'b1; db_cqid = 1'b0; db_head = 3'd4;
    @(negedge clk); db_valid = 1'b0;
    in_valid = 1'b0;
    post(2'd0, 16'h00ee, 1'b0, 3'd7, 1'b1);   // R4 held record posted
    post(2'd1, 16'h00ef, 1'b0, 3'd0, 1'b0);   // R3 wrap, R5 phase inverted
    post(2'd0, 16'h00f0, 1'b0, 3'd1, 1'b0);   // R5
    idle();
  endtask

  task automatic t_thresh();
    cfg_thresh = 8'd3; cfg_timeout = 16'd1000;
    do_reset();
    post(2'd0, 16'h1, 1'b0, 3'd0, 1'b1);
    post(2'd3, 16'h2, 1'b1, 3'd0, 1'b1);
    post(2'd1, 16'h3, 1'b0, 3'd1, 1'b1);
    post(2'd2, 16'h4, 1'b1, 3'd1, 1'b1);
    post(2'd0, 16'h5, 1'b0, 3'd2, 1'b1);
    idle();
    repeat (4) @(negedge clk);
    chk("R6 one irq", irq_cnt, 1);
    chk("R6 irq cycle", irq_cyc, acc_cyc + 1);
    chk("R8 vector", irq_last, 5'd5);
    post(2'd3, 16'h6, 1'b1, 3'd2, 1'b1);
    idle();
    repeat (3) @(negedge clk);
    chk("R8 second queue irq", irq_cnt, 2);
    chk("R8 vector cq1", irq_last, 5'd9);
    chk("R6 restart cycle", irq_cyc, acc_cyc + 1);
  endtask

  task automatic t_timeout();
    cfg_thresh = 8'd100; cfg_timeout = 16'd10;
    do_reset();
    post(2'd2, 16'h55, 1'b1, 3'd0, 1'b1);
    idle();
    repeat (9) @(negedge clk);
    chk("R7 not early", irq_cnt, 0);
    repeat (6) @(negedge clk);
    chk("R7 fired", irq_cnt, 1);
    chk("R7 cycle", irq_cyc, acc_cyc + 11);
    chk("R7 vector", irq_last, 5'd9);
    repeat (20) @(negedge clk);
    chk("R7 no repeat", irq_cnt, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_shared();
        t_full_wrap();
        t_thresh();
        t_timeout();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule